// File: doc/BRIEF.md
# Stereo Serial Audio FIFO Controller

This block is a register-mapped serial audio master with one transmit and one receive queue of stereo words. Each word packs two samples. The left sample sits in the upper half and the right sample in the lower half. A programmable divider counts bit-clock ticks and produces the word-select (left/right) clock. On every left/right edge the serial engine sends one half of the current transmit word, MSB first, starting one bit slot after the edge. In the same slots it captures the serial input into a receive word.

Software reaches the block through a simple word-addressed read/write port. A read of the receive data register pops the receive queue. Water levels for each queue drive alert status bits. An interrupt is raised when an alert is present and its enable bit is set. Sticky error flags record a write to a full transmit queue, a frame that starts with no transmit data, and a receive word lost to a full queue. Writing 1 to a flag clears it.

The bit clock reaches the block as a one-cycle `bit_tick` strobe in the system clock domain. All serial state moves only on that strobe.

Top module: `i2s_fifo_ctrl`

## Requirements
- R1: After reset, the registers read as follows: control 0x0000_2200 (both water levels 2), divide 0x080, status 0x15, error 0. `irq` and `codec_rst` are 0 and `lrck` is 1. Word addresses: control 0, TX data 1, RX data 2, status 3, error 4, divide 5.
- R2: Control bits are: TX enable 0, TX interrupt enable 1, RX enable 2, RX interrupt enable 3, TX water level [10:8], RX water level [14:12], queue flush 16 (self-clearing, reads 0) and codec reset 17 (drives `codec_rst`). Writing bit 16 empties both queues.
- R3: While running, `lrck` toggles exactly once every LRDIV ticks. LRDIV is the 10-bit divide register, and writes keep only bits [9:0]. The first tick after enabling from idle starts a frame and drives `lrck` low.
- R4: In each half-frame, slots 1..16 after the `lrck` edge carry the sample MSB first: word bits [31:16] while `lrck` is low and [15:0] while it is high. Every other slot drives `sdout` to 0.
- R5: A TX data write while the TX queue holds 8 words is dropped and sets error bit 0.
- R6: If a frame starts while TX is enabled and the TX queue is empty, error bit 0 is set and the whole frame is sent as zeros.
- R7: `sdin` is captured in the same slots and layout as R4. The received word is pushed at the end of the frame. Reading RX data returns the oldest word and pops it, and a read of an empty queue returns 0.
- R8: A push into a full RX queue is dropped and sets error bit 1.
- R9: Error bits are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R10: Status bits are: TX alert 0, RX alert 1, TX empty 2, TX full 3, RX empty 4, RX full 5. TX alert means TX free slots > TX water level. RX alert means RX free slots < RX water level.
- R11: `irq` = (TX alert and TX interrupt enable) or (RX alert and RX interrupt enable).
- R12: With TX disabled, no word is popped and `sdout` stays 0. With RX disabled, no word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_word | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_en` is high |
| bit_tick | input | 1 | One-cycle strobe per bit-clock period |
| sdin | input | 1 | Serial audio input |
| sdout | output | 1 | Serial audio output |
| lrck | output | 1 | Left/right word-select clock, low for the left channel |
| irq | output | 1 | Combined queue alert interrupt |
| codec_rst | output | 1 | Codec reset control level |

## Verification
The serial path is tried with eight stereo words fed back from `sdout` to `sdin`. The patterns are all-zero and all-one words, words with only the outer bits set, alternating patterns, and halves that differ. Together they separate a swapped channel order, a reversed bit order, a slot shifted by one, and upper bits leaking into the lower half. A divide of 20 places padding slots after the data so that stray output there is visible. A divide of 17 leaves exactly one idle slot, and the default 128 is checked on the `lrck` period alone. A constant-high input fed past the RX capacity shows the alert, full and overrun thresholds one push at a time, and the read after the eighth word shows that the dropped word was not stored.

// File: rtl/i2s_pkg.sv
`timescale 1ns/1ps
package i2s_pkg;
   // register word addresses
   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_TXD  = 3'd1;
   localparam logic [2:0] RA_RXD  = 3'd2;
   localparam logic [2:0] RA_STAT = 3'd3;
   localparam logic [2:0] RA_ERR  = 3'd4;
   localparam logic [2:0] RA_DIV  = 3'd5;

   // control field positions
   localparam int CB_TXEN  = 0;
   localparam int CB_TXIE  = 1;
   localparam int CB_RXEN  = 2;
   localparam int CB_RXIE  = 3;
   localparam int CB_TXWL  = 8;
   localparam int CB_RXWL  = 12;
   localparam int CB_FLUSH = 16;
   localparam int CB_CODEC = 17;

   // status field positions
   localparam int SB_TXAL = 0;
   localparam int SB_RXAL = 1;
   localparam int SB_TXEM = 2;
   localparam int SB_TXFU = 3;
   localparam int SB_RXEM = 4;
   localparam int SB_RXFU = 5;

   // error field positions
   localparam int EB_TX = 0;
   localparam int EB_RX = 1;

   localparam int WL_W = 3;
endpackage

// File: rtl/i2s_sync_fifo.sv
`timescale 1ns/1ps
module i2s_sync_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   generate
      if ((1 << AW) != DEPTH || DEPTH < 4)
         $error("i2s_sync_fifo: DEPTH must be a power of two, at least 4");
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end
endmodule

// File: rtl/i2s_lr_engine.sv
`timescale 1ns/1ps
module i2s_lr_engine #(
   parameter int SAMPLE_W = 16,
   parameter int DIV_W    = 10,
   localparam int WORD_W  = 2 * SAMPLE_W,
   localparam int PW      = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic [DIV_W-1:0]  div,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tx_avail,
   output logic              tx_pop,
   output logic              underrun,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_word,
   input  logic              sdin,
   output logic              sdout,
   output logic              lrck
);
   generate
      if (DIV_W <= $clog2(SAMPLE_W) + 1)
         $error("i2s_lr_engine: DIV_W too small for SAMPLE_W");
   endgenerate

   logic              running, lr;
   logic [DIV_W-1:0]  cnt, lim, ofs;
   logic [PW-1:0]     pos;
   logic [WORD_W-1:0] cur, cap, cap_next;
   logic              en, half_end, frame_start, slot_data;

   assign en          = tx_en | rx_en;
   assign lim         = (div == '0) ? '0 : div - 1'b1;
   assign half_end    = (cnt >= lim);
   assign frame_start = bit_tick & en & (~running | (half_end & lr));
   assign slot_data   = (cnt != '0) && (cnt <= DIV_W'(SAMPLE_W));
   assign ofs         = DIV_W'(SAMPLE_W) - cnt;
   assign pos         = PW'(ofs) + (lr ? PW'(0) : PW'(SAMPLE_W));

   always_comb begin
      cap_next = cap;
      if (slot_data) cap_next[pos] = sdin;
   end

   assign tx_pop   = frame_start & tx_en & tx_avail;
   assign underrun = frame_start & tx_en & ~tx_avail;
   assign rx_push  = bit_tick & en & rx_en & running & half_end & lr;
   assign rx_word  = cap_next;
   assign sdout    = tx_en & running & slot_data & cur[pos];
   assign lrck     = lr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         lr      <= 1'b1;
         cnt     <= '0;
         cur     <= '0;
         cap     <= '0;
      end else if (bit_tick) begin
         if (!en) begin
            running <= 1'b0;
            lr      <= 1'b1;
            cnt     <= '0;
         end else if (frame_start) begin
            running <= 1'b1;
            lr      <= 1'b0;
            cnt     <= '0;
            cur     <= (tx_en && tx_avail) ? tx_word : '0;
            cap     <= '0;
         end else if (half_end) begin
            lr      <= 1'b1;
            cnt     <= '0;
            cap     <= cap_next;
         end else begin
            cnt     <= cnt + 1'b1;
            cap     <= cap_next;
         end
      end
   end
endmodule

// File: rtl/i2s_csr.sv
`timescale 1ns/1ps
module i2s_csr
   import i2s_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int WORD_W   = 32,
   parameter int DIV_W    = 10,
   parameter int DIV_RST  = 128,
   parameter int WL_RST   = 2,
   parameter int IRQ_REG  = 0,
   localparam int CW      = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [2:0]        bus_word,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CW-1:0]     tx_count,
   input  logic [CW-1:0]     rx_count,
   input  logic              tx_full,
   input  logic              tx_empty,
   input  logic              rx_full,
   input  logic              rx_empty,
   input  logic [WORD_W-1:0] rx_head,
   input  logic              underrun,
   input  logic              rx_push,
   output logic              tx_push,
   output logic              rx_pop,
   output logic              flush,
   output logic              tx_en,
   output logic              rx_en,
   output logic              tx_ie,
   output logic              rx_ie,
   output logic [DIV_W-1:0]  div,
   output logic [1:0]        err,
   output logic              tx_alert,
   output logic              rx_alert,
   output logic              codec_rst,
   output logic              irq
);
   logic [WL_W-1:0] tx_wl, rx_wl;
   logic [CW-1:0]   tx_free, rx_free;
   logic            wr_ctrl, wr_err, wr_div, irq_c;
   logic            tx_err_set, rx_err_set;

   assign wr_ctrl = bus_en & bus_wr & (bus_word == RA_CTRL);
   assign wr_err  = bus_en & bus_wr & (bus_word == RA_ERR);
   assign wr_div  = bus_en & bus_wr & (bus_word == RA_DIV);
   assign tx_push = bus_en & bus_wr & (bus_word == RA_TXD);
   assign rx_pop  = bus_en & ~bus_wr & (bus_word == RA_RXD) & ~rx_empty;
   assign flush   = wr_ctrl & bus_wdata[CB_FLUSH];

   assign tx_err_set = (tx_push & tx_full) | underrun;
   assign rx_err_set = rx_push & rx_full;

   assign tx_free  = CW'(DEPTH) - tx_count;
   assign rx_free  = CW'(DEPTH) - rx_count;
   assign tx_alert = 32'(tx_free) > 32'(tx_wl);
   assign rx_alert = 32'(rx_free) < 32'(rx_wl);
   assign irq_c    = (tx_alert & tx_ie) | (rx_alert & rx_ie);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en     <= 1'b0;
         rx_en     <= 1'b0;
         tx_ie     <= 1'b0;
         rx_ie     <= 1'b0;
         tx_wl     <= WL_W'(WL_RST);
         rx_wl     <= WL_W'(WL_RST);
         codec_rst <= 1'b0;
         div       <= DIV_W'(DIV_RST);
         err       <= '0;
      end else begin
         if (wr_ctrl) begin
            tx_en     <= bus_wdata[CB_TXEN];
            rx_en     <= bus_wdata[CB_RXEN];
            tx_ie     <= bus_wdata[CB_TXIE];
            rx_ie     <= bus_wdata[CB_RXIE];
            tx_wl     <= bus_wdata[CB_TXWL +: WL_W];
            rx_wl     <= bus_wdata[CB_RXWL +: WL_W];
            codec_rst <= bus_wdata[CB_CODEC];
         end
         if (wr_div) div <= bus_wdata[DIV_W-1:0];
         err[EB_TX] <= (err[EB_TX] & ~(wr_err & bus_wdata[EB_TX])) | tx_err_set;
         err[EB_RX] <= (err[EB_RX] & ~(wr_err & bus_wdata[EB_RX])) | rx_err_set;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_word)
         RA_CTRL: begin
            bus_rdata[CB_TXEN]          = tx_en;
            bus_rdata[CB_TXIE]          = tx_ie;
            bus_rdata[CB_RXEN]          = rx_en;
            bus_rdata[CB_RXIE]          = rx_ie;
            bus_rdata[CB_TXWL +: WL_W]  = tx_wl;
            bus_rdata[CB_RXWL +: WL_W]  = rx_wl;
            bus_rdata[CB_CODEC]         = codec_rst;
         end
         RA_RXD:  bus_rdata = rx_empty ? '0 : 32'(rx_head);
         RA_STAT: begin
            bus_rdata[SB_TXAL] = tx_alert;
            bus_rdata[SB_RXAL] = rx_alert;
            bus_rdata[SB_TXEM] = tx_empty;
            bus_rdata[SB_TXFU] = tx_full;
            bus_rdata[SB_RXEM] = rx_empty;
            bus_rdata[SB_RXFU] = rx_full;
         end
         RA_ERR:  bus_rdata[1:0] = err;
         RA_DIV:  bus_rdata = 32'(div);
         default: bus_rdata = '0;
      endcase
   end

   generate
      if (IRQ_REG != 0) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_c;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate
endmodule

// File: rtl/i2s_fifo_ctrl.sv
`timescale 1ns/1ps
module i2s_fifo_ctrl #(
   parameter int DEPTH    = 8,
   parameter int SAMPLE_W = 16,
   parameter int DIV_W    = 10,
   parameter int DIV_RST  = 128,
   parameter int WL_RST   = 2,
   parameter int IRQ_REG  = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_en,
   input  logic        bus_wr,
   input  logic [2:0]  bus_word,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        bit_tick,
   input  logic        sdin,
   output logic        sdout,
   output logic        lrck,
   output logic        irq,
   output logic        codec_rst
);
   localparam int WORD_W = 2 * SAMPLE_W;
   localparam int CW     = $clog2(DEPTH) + 1;

   generate
      if (WORD_W != 32)
         $error("i2s_fifo_ctrl: two samples must fill the 32-bit data word");
      if (DIV_W > 32 || DIV_RST >= (1 << DIV_W))
         $error("i2s_fifo_ctrl: divide reset value does not fit");
      if (WL_RST < 0 || WL_RST >= (1 << i2s_pkg::WL_W))
         $error("i2s_fifo_ctrl: water level reset value does not fit");
   endgenerate

   logic              tx_push, tx_pop, rx_push, rx_pop, flush, underrun;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [CW-1:0]     tx_count, rx_count;
   logic [WORD_W-1:0] tx_head, rx_head, rx_word;
   logic              tx_en, rx_en, tx_ie, rx_ie, tx_alert, rx_alert;
   logic [DIV_W-1:0]  div;
   logic [1:0]        err;

   i2s_csr #(
      .DEPTH(DEPTH), .WORD_W(WORD_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST),
      .WL_RST(WL_RST), .IRQ_REG(IRQ_REG)
   ) u_csr (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full),
      .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
      .rx_head(rx_head), .underrun(underrun), .rx_push(rx_push),
      .tx_push(tx_push), .rx_pop(rx_pop), .flush(flush),
      .tx_en(tx_en), .rx_en(rx_en), .tx_ie(tx_ie), .rx_ie(rx_ie),
      .div(div), .err(err), .tx_alert(tx_alert), .rx_alert(rx_alert),
      .codec_rst(codec_rst), .irq(irq)
   );

   i2s_sync_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push),
      .wdata(bus_wdata[WORD_W-1:0]), .pop(tx_pop), .rdata(tx_head),
      .count(tx_count), .full(tx_full), .empty(tx_empty)
   );

   i2s_sync_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_push),
      .wdata(rx_word), .pop(rx_pop), .rdata(rx_head),
      .count(rx_count), .full(rx_full), .empty(rx_empty)
   );

   i2s_lr_engine #(.SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
      .rx_en(rx_en), .div(div), .tx_word(tx_head), .tx_avail(~tx_empty),
      .tx_pop(tx_pop), .underrun(underrun), .rx_push(rx_push),
      .rx_word(rx_word), .sdin(sdin), .sdout(sdout), .lrck(lrck)
   );
endmodule

// File: rtl/i2s_fifo_ctrl_chk.sv
`timescale 1ns/1ps
module i2s_fifo_ctrl_chk
   import i2s_pkg::*;
#(
   parameter int IRQ_REG = 0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_en,
   input logic        bus_wr,
   input logic [2:0]  bus_word,
   input logic [31:0] bus_wdata,
   input logic        bit_tick,
   input logic        lrck,
   input logic        irq,
   input logic        tx_full,
   input logic        tx_empty,
   input logic        rx_empty,
   input logic        tx_ie,
   input logic        rx_ie,
   input logic [1:0]  err
);
   // R5: write into a full TX queue raises the TX error flag
   assert_full_write_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && bus_word == RA_TXD && tx_full) |=> err[EB_TX]);

   // R9: RX error flag stays set unless cleared by a 1 write
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err[EB_RX] && !(bus_en && bus_wr && bus_word == RA_ERR && bus_wdata[EB_RX]))
      |=> err[EB_RX]);

   // R3: the word-select clock moves only on a bit tick
   assert_lrck_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(lrck));

   // R2: a flush write leaves both queues empty
   assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && bus_word == RA_CTRL && bus_wdata[CB_FLUSH])
      |=> (tx_empty && rx_empty));

   // R10: a queue is never reported full and empty together
   assert_tx_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty));

   generate
      if (IRQ_REG == 0) begin : g_irq_chk
         // R11: no interrupt without an enable
         assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> (tx_ie || rx_ie));
      end
   endgenerate
endmodule

bind i2s_fifo_ctrl i2s_fifo_ctrl_chk #(.IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
   .bus_word(bus_word), .bus_wdata(bus_wdata), .bit_tick(bit_tick),
   .lrck(lrck), .irq(irq), .tx_full(tx_full), .tx_empty(tx_empty),
   .rx_empty(rx_empty), .tx_ie(tx_ie), .rx_ie(rx_ie), .err(err)
);

// File: tb/tb_i2s_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_i2s_fifo_ctrl;
   localparam logic [2:0] A_CTRL = 3'd0, A_TXD = 3'd1, A_RXD = 3'd2,
                          A_STAT = 3'd3, A_ERR = 3'd4, A_DIV = 3'd5;
   // stimulus words; expected serial halves are word[31:16] and word[15:0]
   localparam logic [31:0] TBL [8] = '{
      32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'hA5A5_5A5A,
      32'h1234_ABCD, 32'h0001_8000, 32'hDEAD_BEEF, 32'h7FFF_FFFE };

   logic        clk = 0, rst_n = 0;
   logic        bus_en = 0, bus_wr = 0;
   logic [2:0]  bus_word = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic        bit_tick = 0, sdin, sdout, lrck, irq, codec_rst;
   logic        loopback = 0, ext_sdin = 0;
   int          checks = 0, errors = 0;
   logic [31:0] rv;

   assign sdin = loopback ? sdout : ext_sdin;
   always #5 clk = ~clk;

   i2s_fifo_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bit_tick(bit_tick), .sdin(sdin), .sdout(sdout), .lrck(lrck),
      .irq(irq), .codec_rst(codec_rst));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_en = 1; bus_wr = 1; bus_word = a; bus_wdata = d;
      @(negedge clk); bus_en = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); bus_en = 1; bus_wr = 0; bus_word = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_en = 0;
   endtask

   task automatic tick();
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // one full frame: checks lrck placement (R3), halves (R4) and padding zeros
   task automatic run_frame(input logic [31:0] w, input int dv);
      logic [15:0] l, r;
      int bad_lr, bad_pad;
      l = 0; r = 0; bad_lr = 0; bad_pad = 0;
      for (int t = 0; t < 2 * dv; t++) begin
         tick();
         if (lrck !== ((t >= dv) ? 1'b1 : 1'b0)) bad_lr++;
         if ((t % dv) >= 1 && (t % dv) <= 16) begin
            if (t < dv) l[16 - (t % dv)] = sdout;
            else        r[16 - (t % dv)] = sdout;
         end else if (sdout !== 1'b0) bad_pad++;
      end
      chk("R3 lrck edges in frame", bad_lr, 0);
      chk("R4 left half", {16'h0, l}, {16'h0, w[31:16]});
      chk("R4 right half", {16'h0, r}, {16'h0, w[15:0]});
      chk("R4 padding slots zero", bad_pad, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int ones;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      rd(A_CTRL, rv); chk("R1 ctrl reset", rv, 32'h0000_2200);
      rd(A_DIV,  rv); chk("R1 divide reset", rv, 32'h80);
      rd(A_STAT, rv); chk("R1 status reset", rv, 32'h15);
      rd(A_ERR,  rv); chk("R1 error reset", rv, 0);
      chk("R1 outputs reset", {irq, codec_rst, lrck}, 3'b001);

      // R2 codec reset bit
      wr(A_CTRL, 32'h0002_2200);
      chk("R2 codec_rst set", codec_rst, 1);
      rd(A_CTRL, rv); chk("R2 ctrl readback", rv, 32'h0002_2200);
      wr(A_CTRL, 32'h0000_2200);
      chk("R2 codec_rst clear", codec_rst, 0);

      // R10/R11 TX alert against water level
      for (int i = 0; i < 5; i++) wr(A_TXD, 32'h100 + i);
      rd(A_STAT, rv); chk("R10 five words alert", rv, 32'h11);
      chk("R11 irq off without enable", irq, 0);
      wr(A_CTRL, 32'h0000_2202);
      chk("R11 irq with tx enable", irq, 1);
      wr(A_TXD, 32'h105);
      rd(A_STAT, rv); chk("R10 six words no alert", rv, 32'h10);
      chk("R11 irq drops", irq, 0);
      wr(A_CTRL, 32'h0000_2102);
      rd(A_STAT, rv); chk("R10 level 1 alert", rv, 32'h11);
      chk("R11 irq level 1", irq, 1);
      wr(A_CTRL, 32'h0001_2200);
      rd(A_STAT, rv); chk("R2 flush empties", rv, 32'h15);
      rd(A_CTRL, rv); chk("R2 flush bit reads 0", rv, 32'h0000_2200);

      // R3 default divide 128
      wr(A_TXD, 32'h8000_0000);
      wr(A_CTRL, 32'h0000_2201);
      tick();
      chk("R3 frame start lrck low", lrck, 0);
      chk("R4 slot 0 is zero", sdout, 0);
      tick();
      chk("R4 first data bit MSB", sdout, 1);
      ticks(126);
      chk("R3 lrck held for 128 ticks", lrck, 0);
      tick();
      chk("R3 lrck toggles at 128", lrck, 1);
      wr(A_CTRL, 32'h0000_2200);
      tick();

      // R5 full write dropped, R9 write-one-to-clear
      wr(A_DIV, 32'hFFFF_FC14);
      rd(A_DIV, rv); chk("R3 divide keeps 10 bits", rv, 32'h14);
      for (int i = 0; i < 8; i++) wr(A_TXD, TBL[i]);
      wr(A_TXD, 32'h5555_5555);
      rd(A_ERR, rv); chk("R5 full write flag", rv, 1);
      wr(A_ERR, 32'h0);
      rd(A_ERR, rv); chk("R9 zero write keeps flag", rv, 1);
      wr(A_ERR, 32'h1);
      rd(A_ERR, rv); chk("R9 one write clears", rv, 0);

      // R4/R7 vector table through loopback
      loopback = 1;
      wr(A_CTRL, 32'h0000_2205);
      for (int i = 0; i < 8; i++) run_frame(TBL[i], 20);
      wr(A_CTRL, 32'h0000_2204);
      tick();
      rd(A_ERR, rv);  chk("R6 no underrun with tx off", rv, 0);
      rd(A_STAT, rv); chk("R10 rx full and alert", rv, 32'h27);
      wr(A_CTRL, 32'h0000_2200);
      tick();
      for (int i = 0; i < 8; i++) begin
         rd(A_RXD, rv); chk("R7 received word", rv, TBL[i]);
      end
      rd(A_RXD, rv);  chk("R7 empty read zero", rv, 0);
      rd(A_STAT, rv); chk("R7 queues empty", rv, 32'h15);

      // R6 underrun
      loopback = 0;
      wr(A_CTRL, 32'h0000_2201);
      tick();
      rd(A_ERR, rv); chk("R6 underrun flag", rv, 1);
      ones = 0;
      for (int i = 0; i < 20; i++) begin tick(); if (sdout) ones++; end
      chk("R6 zeros sent", ones, 0);
      wr(A_CTRL, 32'h0000_2200);
      tick();
      wr(A_ERR, 32'h1);

      // R8 RX overrun with constant-high input, divide 17
      ext_sdin = 1;
      wr(A_DIV, 32'd17);
      wr(A_CTRL, 32'h0000_2204);
      tick();
      ticks(7 * 34);
      rd(A_STAT, rv); chk("R10 rx alert at seven", rv, 32'h07);
      chk("R11 irq off before rx enable", irq, 0);
      wr(A_CTRL, 32'h0000_220C);
      chk("R11 irq with rx enable", irq, 1);
      ticks(34);
      rd(A_STAT, rv); chk("R10 rx full at eight", rv, 32'h27);
      rd(A_ERR, rv);  chk("R8 no overrun at eight", rv, 0);
      ticks(34);
      rd(A_ERR, rv);  chk("R8 overrun flag", rv, 2);
      wr(A_CTRL, 32'h0000_2200);
      tick();
      for (int i = 0; i < 8; i++) begin
         rd(A_RXD, rv); chk("R7 all-high word", rv, 32'hFFFF_FFFF);
      end
      rd(A_RXD, rv); chk("R8 dropped word not stored", rv, 0);
      wr(A_ERR, 32'h2);
      rd(A_ERR, rv); chk("R9 rx flag cleared", rv, 0);

      // R12 disabled directions
      ext_sdin = 0;
      loopback = 1;
      wr(A_TXD, 32'h1234_5678);
      wr(A_CTRL, 32'h0000_2204);
      ones = 0;
      for (int i = 0; i < 35; i++) begin tick(); if (sdout) ones++; end
      chk("R12 sdout quiet with tx off", ones, 0);
      rd(A_STAT, rv); chk("R12 tx word kept", rv & 32'h4, 0);
      rd(A_RXD, rv);  chk("R12 rx captured zeros", rv, 0);
      wr(A_CTRL, 32'h0000_2201);
      ticks(34);
      rd(A_STAT, rv); chk("R12 no push with rx off", rv, 32'h15);
      wr(A_CTRL, 32'h0000_2200);
      tick();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule